// File: doc/BRIEF.md
# Stereo Audio Serial Data Transmitter

This block turns pairs of 24-bit two's-complement audio samples into one serial data line. It runs on a fast system clock. The bit clock (`bclk`) and the frame clock (`lrclk`) reach it as ordinary inputs that it samples, so they can come from a local clock generator or from an external master. The line changes only after a falling bit-clock edge. Each channel's word goes out most significant bit first.

One format input picks between two kinds of framing. In MSB-justified framing the left word is sent while the frame clock is high, and it starts in the first bit slot after a frame-clock transition. In I2S-compatible framing the left word is sent while the frame clock is low, and it starts one slot later. Bit slots that carry no payload are driven low.

The block counts bit clocks per frame. When that count is 32, each channel is cut to its 16 most significant bits. When the count is neither 32 nor at least 48, an error output is raised. Samples arrive through a valid/ready handshake into a single holding register. That register is moved into the output pair when the next left channel begins.

Top module: `stereo_ser_tx`

## Requirements
- R1: With `fmt_i2s`=0, the left word is sent while `lrclk` is high and the right word while it is low. Slot 0 is the first falling `bclk` edge at which a new `lrclk` level is seen. Slot k (0..23) carries bit 23-k of the word.
- R2: `sdata` changes only on the system-clock edge that follows a detected falling `bclk` edge. It then holds through the rising edge of `bclk`.
- R3: With `fmt_i2s`=1, the left word is sent while `lrclk` is low. Slot 0 carries no bit of the current word, and slot k (1..24) carries bit 24-k.
- R4: Every slot after the last payload bit, up to the next `lrclk` transition, is driven low.
- R5: When the last complete frame had exactly 32 falling `bclk` edges, only bits 23..8 of each word are sent. In MSB-justified framing they occupy slots 0..15. In I2S-compatible framing, bits 23..9 occupy slots 1..15 and bit 8 goes out in slot 0 of the following half-frame.
- R6: `s_ready` is high while the holding register is empty. A pair is accepted on a clock where `s_valid` and `s_ready` are both high, and `s_ready` is then low from the next clock until the holding register is emptied.
- R7: On the falling `bclk` edge that starts a left channel, the held pair becomes the pair sent in that frame and the holding register empties. If no pair is held, the frame sends zeros in both channels.
- R8: `ratio_err` is updated only when a left channel starts after at least one earlier left start. It becomes 1 if the frame just ended had a falling-edge count that is neither 32 nor 48 or more, and 0 otherwise.
- R9: While `rst_n` is low, `sdata`=0, `s_ready`=1 and `ratio_err`=0. After reset, `sdata` stays 0 until the first left-channel start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low reset and power-down |
| fmt_i2s | input | 1 | 0: MSB-justified framing, 1: I2S-compatible framing |
| bclk | input | 1 | Bit clock, sampled on `clk` |
| lrclk | input | 1 | Frame clock, sampled on `clk` |
| s_valid | input | 1 | Sample pair offered |
| s_left | input | 24 | Left sample, two's complement |
| s_right | input | 24 | Right sample, two's complement |
| s_ready | output | 1 | Holding register empty |
| sdata | output | 1 | Serial data line |
| ratio_err | output | 1 | Unsupported bit-clock to frame ratio |

## Verification
A new `sdata` bit is due on the first `clk` edge after the bench lowers `bclk`. The bench therefore reads the line two cycles after the fall and again four cycles after it, just before the rise, and requires both reads to agree. `s_ready` is due to fall one cycle after an accepted pair, so the bench reads it on the next falling `clk` edge. `ratio_err` is due one cycle after the second left-channel start, so the bench reads it only after whole frames have finished. Expected slot contents are placed in a slot-indexed ring when each frame's pair leaves the scoreboard queue. In I2S 32fs runs, a bit can land in the next half-frame, and the ring places it there.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int unsigned DEF_SAMPLE_W    = 24;
  localparam int unsigned DEF_SHORT_W     = 16;
  localparam int unsigned DEF_SHORT_RATIO = 32;
  localparam int unsigned DEF_MIN_RATIO   = 48;

  // a frame length is acceptable when it is the short ratio or at least the minimum
  function automatic logic ratio_bad(input int unsigned r, input int unsigned short_r,
                                     input int unsigned min_r);
    return (r != short_r) && (r < min_r);
  endfunction
endpackage

// File: rtl/sst_edge.sv
module sst_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic fmt_i2s,
  input  logic bclk,
  input  logic lrclk,
  output logic bit_fall,
  output logic half_start,
  output logic left_start,
  output logic chan_left
);
  logic bclk_q;
  logic lr_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      lr_last <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (bit_fall) lr_last <= lrclk;
    end
  end

  assign bit_fall   = bclk_q & ~bclk;
  assign chan_left  = lrclk ^ fmt_i2s;          // high level = left unless I2S
  assign half_start = bit_fall & (lrclk ^ lr_last);
  assign left_start = half_start & chan_left;
endmodule

// File: rtl/sst_rate.sv
module sst_rate #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SHORT_RATIO = sst_pkg::DEF_SHORT_RATIO,
  parameter int unsigned MIN_RATIO   = sst_pkg::DEF_MIN_RATIO
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_fall,
  input  logic left_start,
  output logic short_mode,
  output logic ratio_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             armed;
  logic             valid_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ratio_q;
  logic             frame_done;
  logic [CNT_W-1:0] ratio_nx;
  logic             valid_nx;

  assign frame_done = left_start & armed;
  assign ratio_nx   = frame_done ? cnt : ratio_q;
  assign valid_nx   = valid_q | frame_done;
  assign short_mode = valid_nx && (ratio_nx == CNT_W'(SHORT_RATIO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      valid_q   <= 1'b0;
      cnt       <= '0;
      ratio_q   <= '0;
      ratio_err <= 1'b0;
    end else if (left_start) begin
      armed <= 1'b1;
      cnt   <= CNT_W'(1);
      if (armed) begin
        ratio_q   <= cnt;
        valid_q   <= 1'b1;
        ratio_err <= sst_pkg::ratio_bad(int'(cnt), SHORT_RATIO, MIN_RATIO);
      end
    end else if (bit_fall && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  p_err_frame_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !left_start |=> $stable(ratio_err));
endmodule

// File: rtl/sst_hold.sv
module sst_hold #(
  parameter int unsigned W = sst_pkg::DEF_SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         s_valid,
  input  logic [W-1:0] s_left,
  input  logic [W-1:0] s_right,
  output logic         s_ready,
  output logic [W-1:0] now_l,
  output logic [W-1:0] now_r,
  output logic [W-1:0] old_r
);
  logic         pend_full;
  logic [W-1:0] pend_l, pend_r, cur_l, cur_r;
  logic         accept;

  assign s_ready = ~pend_full;
  assign accept  = s_valid & ~pend_full;
  assign now_l   = take ? (pend_full ? pend_l : '0) : cur_l;
  assign now_r   = take ? (pend_full ? pend_r : '0) : cur_r;
  assign old_r   = cur_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_full <= 1'b0;
      pend_l    <= '0;
      pend_r    <= '0;
      cur_l     <= '0;
      cur_r     <= '0;
    end else begin
      if (take) begin
        cur_l <= now_l;
        cur_r <= now_r;
      end
      if (accept) begin
        pend_l    <= s_left;
        pend_r    <= s_right;
        pend_full <= 1'b1;
      end else if (take) begin
        pend_full <= 1'b0;
      end
    end
  end

  p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);
  p_hold_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_full && !take) |=> (pend_full && $stable(pend_l) && $stable(pend_r)));
endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx #(
  parameter int unsigned SAMPLE_W    = sst_pkg::DEF_SAMPLE_W,
  parameter int unsigned SHORT_W     = sst_pkg::DEF_SHORT_W,
  parameter int unsigned SHORT_RATIO = sst_pkg::DEF_SHORT_RATIO,
  parameter int unsigned MIN_RATIO   = sst_pkg::DEF_MIN_RATIO,
  parameter int unsigned SLOT_W      = 6,
  parameter int unsigned CNT_W       = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fmt_i2s,
  input  logic                bclk,
  input  logic                lrclk,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                s_ready,
  output logic                sdata,
  output logic                ratio_err
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic bit_fall, half_start, left_start, chan_left, short_mode;
  logic [SAMPLE_W-1:0] now_l, now_r, old_r, word, prev;
  logic [SLOT_W-1:0] slot_q, slot_nx;
  logic synced_q, next_bit;

  // bit carried by a slot: I2S slot 0 holds only the spilled 16th bit in short mode
  function automatic logic pick_bit(input logic [SAMPLE_W-1:0] w, input logic [SAMPLE_W-1:0] p,
                                    input logic [SLOT_W-1:0] s, input logic i2s, input logic sh);
    int unsigned pos;
    int unsigned nb;
    if (i2s && s == '0) return sh ? p[SAMPLE_W-SHORT_W] : 1'b0;
    pos = int'(s) - (i2s ? 1 : 0);
    nb  = sh ? SHORT_W : SAMPLE_W;
    if (pos < nb) return w[SAMPLE_W-1-pos];
    return 1'b0;
  endfunction

  sst_edge u_edge (
    .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .bclk(bclk), .lrclk(lrclk),
    .bit_fall(bit_fall), .half_start(half_start), .left_start(left_start), .chan_left(chan_left)
  );

  sst_rate #(.CNT_W(CNT_W), .SHORT_RATIO(SHORT_RATIO), .MIN_RATIO(MIN_RATIO)) u_rate (
    .clk(clk), .rst_n(rst_n), .bit_fall(bit_fall), .left_start(left_start),
    .short_mode(short_mode), .ratio_err(ratio_err)
  );

  sst_hold #(.W(SAMPLE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .take(left_start), .s_valid(s_valid),
    .s_left(s_left), .s_right(s_right), .s_ready(s_ready),
    .now_l(now_l), .now_r(now_r), .old_r(old_r)
  );

  assign slot_nx  = half_start ? '0 : ((slot_q == SLOT_MAX) ? slot_q : slot_q + 1'b1);
  assign word     = chan_left ? now_l : now_r;
  assign prev     = chan_left ? old_r : now_l;
  assign next_bit = pick_bit(word, prev, slot_nx, fmt_i2s, short_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= '0;
      synced_q <= 1'b0;
      sdata    <= 1'b0;
    end else if (bit_fall) begin
      slot_q <= slot_nx;
      sdata  <= (synced_q | left_start) & next_bit;
      if (left_start) synced_q <= 1'b1;
    end
  end

  p_sdata_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_fall |=> $stable(sdata));
  p_quiet_before_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!synced_q && !left_start) |=> !sdata);
endmodule

// File: tb/stereo_ser_tx_test.sv
`timescale 1ns/1ps
module stereo_ser_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_i2s = 1'b0;
  logic        bclk = 1'b1;
  logic        lrclk = 1'b0;
  logic        s_valid = 1'b0;
  logic [23:0] s_left = '0;
  logic [23:0] s_right = '0;
  logic        s_ready, sdata, ratio_err;

  int nvec = 0;
  int nbad = 0;
  logic        ring_v [256];
  string       ring_t [256];
  logic [47:0] expq [$];
  logic [31:0] lcg = 32'h1357_9bdf;

  always #2.5 clk = ~clk;

  stereo_ser_tx uut (
    .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .bclk(bclk), .lrclk(lrclk),
    .s_valid(s_valid), .s_left(s_left), .s_right(s_right), .s_ready(s_ready),
    .sdata(sdata), .ratio_err(ratio_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic next_pair(output logic [47:0] p);
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    p[47:24] = lcg[31:8];
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    p[23:0] = lcg[30:7];
  endtask

  // reset state (R9); right-channel level is equal to the format bit
  task automatic do_reset(input bit i2s);
    rst_n = 1'b0; s_valid = 1'b0; fmt_i2s = i2s; bclk = 1'b1; lrclk = i2s;
    wait_n(3);
    chk("R9", sdata, 0);
    chk("R9", s_ready, 1);
    chk("R9", ratio_err, 0);
    rst_n = 1'b1;
    wait_n(2);
  endtask

  // scoreboard: expected bits of one frame placed by absolute slot number
  task automatic place(input logic [47:0] pr, input int base, input int half, input bit i2s,
                       input bit sh, input string tag);
    int nb = sh ? 16 : 24;
    for (int ch = 0; ch < 2; ch++) begin
      logic [23:0] w = (ch == 0) ? pr[47:24] : pr[23:0];
      int hb = base + ch * half;
      for (int b = 0; b < nb; b++) begin
        int s = b + (i2s ? 1 : 0);
        int idx = -1;
        if (s < half) idx = (hb + s) % 256;
        else if (i2s && sh && s == half) idx = (hb + half) % 256;
        if (idx >= 0) begin
          ring_v[idx] = w[23-b];
          ring_t[idx] = tag;
        end
      end
    end
  endtask

  task automatic run_case(input bit i2s, input int half, input int nfr, input int npairs,
                          input string ttag);
    int abs_s = 0;
    bit sh = (2 * half == 32);
    logic [47:0] pr;
    logic a;
    do_reset(i2s);
    for (int i = 0; i < 256; i++) begin ring_v[i] = 1'b0; ring_t[i] = "R4"; end
    expq.delete();
    for (int s = 0; s < half; s++) begin
      bclk = 1'b0; wait_n(4);
      chk("R9", sdata, 0);
      bclk = 1'b1; wait_n(4);
    end
    for (int f = 0; f < nfr; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        for (int s = 0; s < half; s++) begin
          int idx = abs_s % 256;
          if (s == 0) lrclk = (ch == 0) ? ~i2s : i2s;
          if (ch == 0 && s == 0) begin
            if (expq.size() > 0) place(expq.pop_front(), abs_s, half, i2s, sh, ttag);
            else place(48'h0, abs_s, half, i2s, sh, "R7");
          end
          bclk = 1'b0;
          wait_n(2);
          a = sdata;
          wait_n(2);
          chk("R2", sdata, a);
          chk(ring_t[idx], sdata, ring_v[idx]);
          ring_v[idx] = 1'b0; ring_t[idx] = "R4";
          bclk = 1'b1;
          if (ch == 1 && s == 2 && f < npairs) begin
            next_pair(pr);
            chk("R6", s_ready, 1);
            s_valid = 1'b1; s_left = pr[47:24]; s_right = pr[23:0];
            wait_n(1);
            s_valid = 1'b0;
            chk("R6", s_ready, 0);
            expq.push_back(pr);
            wait_n(3);
          end else begin
            wait_n(4);
          end
          abs_s++;
        end
      end
    end
    chk("R8", ratio_err, (2 * half == 32 || 2 * half >= 48) ? 0 : 1);
  endtask

  initial begin
    run_case(1'b0, 32, 5, 3, "R1");  // MSB-justified 64fs, last frame underruns
    run_case(1'b1, 32, 4, 3, "R3");  // I2S 64fs
    run_case(1'b0, 16, 5, 4, "R5");  // MSB-justified 32fs
    run_case(1'b1, 16, 5, 4, "R5");  // I2S 32fs, bit 8 spills into next half
    run_case(1'b0, 24, 4, 3, "R8");  // 48fs, exact fit, no error
    run_case(1'b1, 20, 4, 3, "R8");  // 40fs, error raised
    do_reset(1'b0);                  // R9: error cleared by reset
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule